// File: doc/BRIEF.md
# Frame-Rate Ratio Detector

This block works out, with no configuration, how many master-clock cycles make up one audio frame. The frame (word-select) signal comes from outside and is frequency-locked to the master clock. The block synchronises the frame signal and times the interval between its rising edges. It then sorts each interval into one of six oversampling ratios: 128, 192, 256, 384, 512 or 768 times the sample rate. For example, a 12.288 MHz master clock gives 256fs at 48 kHz, 384fs at 32 kHz and 768fs at 16 kHz. The clock dividers downstream read the result as a 3-bit code and a lock flag.

A mode pin selects low-sample-rate operation. In that mode the noise shaper runs at 128fs instead of 64fs, so the two smallest ratios leave too few master cycles per frame and are illegal. An interval that matches no ratio, a ratio that the current mode forbids, or a frame clock that stops all drop lock and raise an error flag. Lock needs a run of identical classifications before it is reported. The master clock has to keep running while reset is asserted, because every register resets synchronously.

Top module: `fs_ratio_detect`

## Requirements
- R1: While reset is held and in the cycle after it, `ratio_code` is 7, `ratio_locked` is 0 and `ratio_err` is 0.
- R2: One measured interval is the number of `clk` cycles between two consecutive rising edges of `frame_in`. It maps to code 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768. Code 7 means no ratio.
- R3: An interval is accepted within ±TOL cycles of a nominal ratio (default TOL = 2). With the defaults, 254 and 386 are accepted and 259 is rejected.
- R4: Lock is reported only after LOCK_RUNS consecutive intervals (default 2) give the same code. While unlocked the code reads 7. The first rising edge after reset only starts the timing.
- R5: A valid interval of a different ratio while locked drops lock and shows code 7, with no error. Lock returns once that new ratio repeats.
- R6: An interval that matches no ratio sets `ratio_err`, clears lock and shows code 7. The next matching interval clears `ratio_err`. Error and lock are never high together.
- R7: With `low_fs_mode` high, intervals of 128 and 192 are handled as in R6. Ratios 256 and above lock as usual.
- R8: If `frame_in` has no rising edge for more than 768+TOL+1 cycles after a previous rising edge, the block sets `ratio_err` and clears lock without waiting for the next edge.
- R9: The outputs change only in the cycle after an interval completes or a stall is detected. A rising edge on `frame_in` shows its effect at the outputs after the fourth rising `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_in | input | 1 | Asynchronous frame (word-select) clock |
| low_fs_mode | input | 1 | Low-sample-rate operating mode; quasi-static |
| ratio_code | output | 3 | Detected ratio code, 7 = none |
| ratio_locked | output | 1 | Ratio confirmed over consecutive frames |
| ratio_err | output | 1 | Last interval was illegal or the frame clock stalled |

## Verification
The stall case is the hardest to reach from the ports. The bench gets there by holding the frame input low for well over 771 cycles straight after a valid period, so the saturating timer must raise the error with no edge to trigger it. The recovery afterwards is checked too: the first interval after the stall is itself out of range, and relock needs two clean periods. Tolerance edges are reached by driving periods exactly TOL and TOL+1 away from a nominal. Mode filtering is reached by switching the low-rate pin between runs of legal and forbidden ratios.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   localparam int NUM_RATIOS = 6;

   typedef logic [2:0] ratio_code_t;

   localparam ratio_code_t CODE_NONE = 3'd7;

   // Nominal cycle count for ratio index: even → 128·2^(i/2), odd → 192·2^(i/2)
   function automatic int nominal_ratio(input int idx);
      int base;
      base = ((idx % 2) == 0) ? 128 : 192;
      return base << (idx / 2);
   endfunction

   // Indices forbidden in low-sample-rate mode (128 and 192)
   function automatic bit banned_low_fs(input int idx);
      return (idx < 2);
   endfunction

endpackage

// File: rtl/fsr_sync_edge.sv
module fsr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fsr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], async_in};
         last_q <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/fsr_period_counter.sv
module fsr_period_counter #(
   parameter int LIMIT = 771,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic [CNT_W-1:0] meas,
   output logic             meas_vld,
   output logic             overrun
);

   if ((LIMIT + 1) >= (1 << CNT_W)) begin : g_bad_width
      $error("fsr_period_counter: CNT_W too small for LIMIT");
   end

   localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] WARN_C = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt;
   logic             seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         seen     <= 1'b0;
         meas     <= '0;
         meas_vld <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         meas_vld <= 1'b0;
         overrun  <= 1'b0;
         if (rise) begin
            meas     <= cnt + 1'b1;
            meas_vld <= seen;
            cnt      <= '0;
            seen     <= 1'b1;
         end else if (seen) begin
            if (cnt < LIM_C) cnt <= cnt + 1'b1;
            if (cnt == WARN_C) overrun <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fsr_classifier.sv
module fsr_classifier #(
   parameter int CNT_W = 10,
   parameter int TOL   = 2
) (
   input  logic                 [CNT_W-1:0] meas,
   input  logic                             low_fs_mode,
   output logic                             cand_ok,
   output fsr_pkg::ratio_code_t             cand_code
);

   import fsr_pkg::*;

   logic [NUM_RATIOS-1:0] hit;
   logic [NUM_RATIOS-1:0] ban;

   for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
      localparam int NOM = nominal_ratio(g);
      localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
      localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
      assign hit[g] = (meas >= LO) && (meas <= HI);
      assign ban[g] = low_fs_mode && banned_low_fs(g);
   end

   always_comb begin
      cand_ok   = 1'b0;
      cand_code = CODE_NONE;
      for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
         if (hit[i] && !ban[i]) begin
            cand_ok   = 1'b1;
            cand_code = ratio_code_t'(i);
         end
      end
   end

endmodule

// File: rtl/fsr_lock_tracker.sv
module fsr_lock_tracker #(
   parameter int LOCK_RUNS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 meas_vld,
   input  logic                 overrun,
   input  logic                 cand_ok,
   input  fsr_pkg::ratio_code_t cand_code,
   output fsr_pkg::ratio_code_t code_q,
   output logic                 locked_q,
   output logic                 err_q
);

   import fsr_pkg::*;

   localparam int RUN_W = $clog2(LOCK_RUNS + 1) + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUNS);

   ratio_code_t      prev_code;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nx;
   logic             same;
   logic             lock_nx;

   always_comb begin
      same    = (cand_code == prev_code) && (run_q != '0);
      if (same) run_nx = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
      else      run_nx = RUN_W'(1);
      lock_nx = (run_nx >= RUN_MAX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q    <= CODE_NONE;
         locked_q  <= 1'b0;
         err_q     <= 1'b0;
         prev_code <= CODE_NONE;
         run_q     <= '0;
      end else if (overrun || (meas_vld && !cand_ok)) begin
         code_q    <= CODE_NONE;
         locked_q  <= 1'b0;
         err_q     <= 1'b1;
         prev_code <= CODE_NONE;
         run_q     <= '0;
      end else if (meas_vld) begin
         prev_code <= cand_code;
         run_q     <= run_nx;
         locked_q  <= lock_nx;
         code_q    <= lock_nx ? cand_code : CODE_NONE;
         err_q     <= 1'b0;
      end
   end

endmodule

// File: rtl/fs_ratio_detect.sv
module fs_ratio_detect #(
   parameter int SYNC_STAGES = 2,
   parameter int TOL         = 2,
   parameter int LOCK_RUNS   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_in,
   input  logic       low_fs_mode,
   output logic [2:0] ratio_code,
   output logic       ratio_locked,
   output logic       ratio_err
);

   import fsr_pkg::*;

   localparam int MAX_NOM = nominal_ratio(NUM_RATIOS - 1);
   localparam int LIMIT   = MAX_NOM + TOL + 1;
   localparam int CNT_W   = $clog2(LIMIT + 2);

   if (TOL < 0 || TOL >= 32) begin : g_bad_tol
      $error("fs_ratio_detect: TOL must lie in 0..31 so windows stay disjoint");
   end
   if (LOCK_RUNS < 1) begin : g_bad_runs
      $error("fs_ratio_detect: LOCK_RUNS must be at least 1");
   end

   logic             w_rise;
   logic [CNT_W-1:0] w_meas;
   logic             w_meas_vld;
   logic             w_overrun;
   logic             w_cand_ok;
   ratio_code_t      w_cand_code;
   ratio_code_t      w_code;

   fsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (frame_in),
      .rise     (w_rise)
   );

   fsr_period_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (w_rise),
      .meas     (w_meas),
      .meas_vld (w_meas_vld),
      .overrun  (w_overrun)
   );

   fsr_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
      .meas        (w_meas),
      .low_fs_mode (low_fs_mode),
      .cand_ok     (w_cand_ok),
      .cand_code   (w_cand_code)
   );

   fsr_lock_tracker #(.LOCK_RUNS(LOCK_RUNS)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .meas_vld  (w_meas_vld),
      .overrun   (w_overrun),
      .cand_ok   (w_cand_ok),
      .cand_code (w_cand_code),
      .code_q    (w_code),
      .locked_q  (ratio_locked),
      .err_q     (ratio_err)
   );

   assign ratio_code = w_code;

endmodule

// File: rtl/fsr_chk.sv
module fsr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       low_fs_mode,
   input logic [2:0] ratio_code,
   input logic       ratio_locked,
   input logic       ratio_err,
   input logic       meas_vld,
   input logic       overrun
);

   // R2
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_code <= 3'd5) || (ratio_code == 3'd7));

   // R4
   lock_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_locked |-> (ratio_code != 3'd7));

   // R4
   lock_from_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ratio_locked) |-> ($past(ratio_code) == 3'd7));

   // R6
   err_excl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ratio_err && ratio_locked));

   // R7
   low_fs_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ratio_locked) && $past(low_fs_mode)) |-> (ratio_code >= 3'd2));

   // R9
   quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(meas_vld) && !$past(overrun)) |->
         $stable({ratio_code, ratio_locked, ratio_err}));

endmodule

bind fs_ratio_detect fsr_chk u_fsr_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .low_fs_mode  (low_fs_mode),
   .ratio_code   (ratio_code),
   .ratio_locked (ratio_locked),
   .ratio_err    (ratio_err),
   .meas_vld     (w_meas_vld),
   .overrun      (w_overrun)
);

// File: tb/tb_fs_ratio_detect.sv
module tb_fs_ratio_detect;

   localparam int TOL   = 2;
   localparam int LIMIT = 768 + TOL + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame = 1'b0;
   logic       low_fs = 1'b0;
   logic [2:0] code;
   logic       locked;
   logic       err;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fs_ratio_detect dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_in     (frame),
      .low_fs_mode  (low_fs),
      .ratio_code   (code),
      .ratio_locked (locked),
      .ratio_err    (err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int nominal[6] = '{128, 192, 256, 384, 512, 768};
   int h [$];
   int since, seen, p_vld, p_ovr, p_meas, m_prev, m_run;
   int e_code, e_lock, e_err;

   function automatic int classify(input int m, input bit lowfs);
      for (int i = 0; i < 6; i++) begin
         if (m >= nominal[i] - TOL && m <= nominal[i] + TOL)
            return (lowfs && i < 2) ? -1 : i;
      end
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         h = '{0, 0, 0};
         since = 0; seen = 0; p_vld = 0; p_ovr = 0; p_meas = 0;
         m_prev = -1; m_run = 0;
         e_code = 7; e_lock = 0; e_err = 0;
      end else begin
         int cand, n_vld, n_ovr, n_meas;
         cand = (p_vld != 0) ? classify(p_meas, low_fs) : -1;
         if (p_ovr != 0 || (p_vld != 0 && cand < 0)) begin
            e_code = 7; e_lock = 0; e_err = 1; m_prev = -1; m_run = 0;
         end else if (p_vld != 0) begin
            if (cand == m_prev) m_run = (m_run >= 2) ? 2 : m_run + 1;
            else begin m_prev = cand; m_run = 1; end
            e_lock = (m_run >= 2) ? 1 : 0;
            e_code = (e_lock != 0) ? cand : 7;
            e_err  = 0;
         end
         n_vld = 0; n_ovr = 0; n_meas = p_meas;
         if (h[1] == 1 && h[2] == 0) begin
            n_vld = seen; n_meas = since + 1; since = 0; seen = 1;
         end else if (seen != 0) begin
            if (since == LIMIT - 1) n_ovr = 1;
            if (since < LIMIT) since++;
         end
         p_vld = n_vld; p_ovr = n_ovr; p_meas = n_meas;
         h.push_front(int'(frame));
         void'(h.pop_back());
      end
   end

   // R9: per-cycle comparison with the reference timing
   always @(negedge clk) begin
      if (rst_n && !done)
         chk(code == 3'(e_code) && locked == e_lock[0] && err == e_err[0], "R9 model",
             int'({code, locked, err}), (e_code << 2) | (e_lock << 1) | e_err);
   end

   // ---------------- stimulus ----------------
   task automatic period(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame <= (i < n / 2);
      end
   endtask

   task automatic run(input int n, input int k);
      for (int j = 0; j < k; j++) period(n);
   endtask

   task automatic expect_out(input string tag, input int c, input int l, input int e);
      chk(code == 3'(c) && locked == l[0] && err == e[0], tag,
          int'({code, locked, err}), (c << 2) | (l << 1) | e);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      expect_out("R1 reset hold", 7, 0, 0);
      rst_n <= 1'b1;
      @(negedge clk);
      expect_out("R1 after reset", 7, 0, 0);

      run(256, 2);
      expect_out("R4 one interval no lock", 7, 0, 0);
      run(256, 1);
      expect_out("R4 lock after two", 2, 1, 0);

      run(128, 3); expect_out("R2 ratio 128", 0, 1, 0);
      run(192, 3); expect_out("R2 ratio 192", 1, 1, 0);
      run(384, 3); expect_out("R2 ratio 384", 3, 1, 0);
      run(512, 3); expect_out("R2 ratio 512", 4, 1, 0);
      run(768, 3); expect_out("R2 ratio 768", 5, 1, 0);

      run(384, 2); expect_out("R5 change drops lock", 7, 0, 0);
      run(384, 1); expect_out("R5 relock", 3, 1, 0);

      run(386, 3); expect_out("R3 upper edge", 3, 1, 0);
      run(254, 3); expect_out("R3 lower edge", 2, 1, 0);
      run(259, 2); expect_out("R3 R6 out of window", 7, 0, 1);
      run(256, 2); expect_out("R6 error clears", 7, 0, 0);
      run(300, 2); expect_out("R6 no match", 7, 0, 1);

      low_fs <= 1'b1;
      run(128, 3); expect_out("R7 low fs 128", 7, 0, 1);
      run(192, 3); expect_out("R7 low fs 192", 7, 0, 1);
      run(256, 3); expect_out("R7 low fs 256", 2, 1, 0);
      low_fs <= 1'b0;
      run(128, 3); expect_out("R7 normal 128", 0, 1, 0);

      run(512, 3);
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         frame <= 1'b0;
      end
      expect_out("R8 stall", 7, 0, 1);
      run(512, 2); expect_out("R8 first after stall", 7, 0, 0);
      run(512, 1); expect_out("R8 recover", 4, 1, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule